// File: doc/BRIEF.md
# Stack-Frame Register Address Unit

This block produces the register-file addresses for a stack-oriented microcoded processor. It holds two pointers, the top-of-stack pointer (TOS) and the argument pointer (ARG). Every cycle it decodes the read, write, pointer-update and conditional-write fields of the current microinstruction, together with an 8-bit microcode constant K and a 6-bit operand N. From these it forms a first read address, a second read address or the name of a non-register operand source, a write address and a write enable. At the clock edge it moves TOS and ARG as the microinstruction directs.

Logical addresses are 6 bits. Octal 060–067 are temporaries shared by every frame. All other addresses belong to the current frame, and 070–073 hold the frame's fixed registers, including the implicit PC. The unit prefixes each register address with a bank bit. For frame registers the bank bit comes from the frame-select input. For temporaries it is always 0. The two loop-exit flags ARG==0 and ARG>TOS are taken from the pointer values before the cycle's update, so a repeat loop tests the state it is iterating on. Neither pointer is checked for overflow: both wrap modulo 64.

There is no state machine. The only state is the two pointer registers, and every output is a combinational function of those registers and the current fields.

Top module: `stack_raddr_unit`

## Requirements
- R1: After reset TOS and ARG are both 0. With first-read select TOS, `rd1_addr` is 0, `arg_zero` is 1 and `arg_gt_tos` is 0.
- R2: The first-read select chooses the low 6 bits of `rd1_addr` as follows: 0 = current TOS, 1 = K[5:0], 2 = N, 3 = current ARG.
- R3: The second-read select sets `d2_src` and `rd2_addr` as follows. Code 0 gives d2_src=0 (register) with the first read address minus one, modulo 64. Code 3 gives d2_src=0 with current TOS. Code 1 gives d2_src=1 (instruction buffer). Code 2 gives d2_src=2 (PC quad address). Code 4 gives d2_src=3 (opcode). Codes 8–15 give d2_src=4 (constant) with `d2_const` equal to code minus 8. Codes 5–7 give d2_src=7 (none). Whenever d2_src is not 0, `rd2_addr` is all zeros.
- R4: The write select chooses the low 6 bits of `wr_addr` as follows: 0 = TOS after this cycle's update, 1 = K[5:0], 2 = N, 3 = current ARG.
- R5: The TOS update codes take effect at the clock edge: 0 holds, 1 adds one, 2 subtracts one, 3 loads ARG, 4 loads N. Codes 5–7 hold.
- R6: The ARG update codes take effect at the clock edge: 0 holds, 1 subtracts one, 2 adds four, 3 clears, 4 loads N. Codes 5–7 hold.
- R7: `arg_zero` and `arg_gt_tos` (unsigned compare) reflect the pointer values held during the current cycle, not the updated values.
- R8: `wr_en` is `wr_req` when `cond_wr` is 0, and `wr_req AND cond_true` when `cond_wr` is 1.
- R9: Bit 6 of `rd1_addr`, `rd2_addr` (register source) and `wr_addr` is 0 when the low 6 bits lie in octal 060–067, and equals `frame_sel` otherwise.
- R10: Both pointers wrap modulo 64 with no overflow check. TOS decremented from 0 becomes 63, and ARG at 62 plus four becomes 2.
- R11: `opnd_swap` follows `swap_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd1_sel | input | 2 | First read address select |
| rd2_sel | input | 4 | Second read operand select |
| swap_in | input | 1 | Operand exchange request |
| wr_sel | input | 2 | Write address select |
| tos_act | input | 3 | TOS update code |
| arg_act | input | 3 | ARG update code |
| wr_req | input | 1 | Microinstruction requests a register write |
| cond_wr | input | 1 | Write only if the condition holds |
| cond_true | input | 1 | Selected condition result |
| frame_sel | input | 1 | Current frame bank |
| k_const | input | 8 | Microcode constant K |
| n_opd | input | 6 | Operand N |
| rd1_addr | output | 7 | First read port address (bank, address) |
| rd2_addr | output | 7 | Second read port address (bank, address) |
| d2_src | output | 3 | Source of the second operand |
| d2_const | output | 3 | Small constant for the second operand |
| opnd_swap | output | 1 | Exchange D1 and D2 |
| wr_addr | output | 7 | Write port address (bank, address) |
| wr_en | output | 1 | Register write enable |
| arg_zero | output | 1 | ARG equals zero |
| arg_gt_tos | output | 1 | ARG greater than TOS |

## Verification
A wrong TOS or ARG value shows up in the same cycle at `rd1_addr`, `rd2_addr` and `wr_addr`, and in the two flags. An update code that misbehaves is therefore exposed one clock after it is issued, by the next microinstruction that reads the pointer. A fault in the post-update path feeding the write address shows up immediately, as a `wr_addr` that differs from the following cycle's TOS. Bank and conditional-write errors depend only on the current fields, so they appear at the ports without delay.

// File: rtl/raddr_pkg.sv
package raddr_pkg;

    typedef enum logic [1:0] {
        SEL_TOS = 2'd0,
        SEL_K   = 2'd1,
        SEL_N   = 2'd2,
        SEL_ARG = 2'd3
    } ptr_sel_e;

    typedef enum logic [2:0] {
        TOS_HOLD   = 3'd0,
        TOS_INC    = 3'd1,
        TOS_DEC    = 3'd2,
        TOS_LD_ARG = 3'd3,
        TOS_LD_N   = 3'd4
    } tos_act_e;

    typedef enum logic [2:0] {
        ARG_HOLD = 3'd0,
        ARG_DEC  = 3'd1,
        ARG_INC4 = 3'd2,
        ARG_CLR  = 3'd3,
        ARG_LD_N = 3'd4
    } arg_act_e;

    typedef enum logic [2:0] {
        D2_REG   = 3'd0,
        D2_IBUF  = 3'd1,
        D2_PCQ   = 3'd2,
        D2_OPC   = 3'd3,
        D2_CONST = 3'd4,
        D2_NONE  = 3'd7
    } d2_src_e;

endpackage

// File: rtl/raddr_ptr_unit.sv
module raddr_ptr_unit
    import raddr_pkg::*;
#(
    parameter int AW       = 6,
    parameter int ARG_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    tos_act,
    input  logic [2:0]    arg_act,
    input  logic [AW-1:0] n_opd,
    output logic [AW-1:0] tos_q,
    output logic [AW-1:0] arg_q,
    output logic [AW-1:0] tos_nx
);
    localparam logic [AW-1:0] ONE  = AW'(1);
    localparam logic [AW-1:0] STEP = AW'(ARG_STEP);

    logic [AW-1:0] arg_nx;

    always_comb begin
        tos_nx = tos_q;
        case (tos_act_e'(tos_act))
            TOS_INC:    tos_nx = tos_q + ONE;
            TOS_DEC:    tos_nx = tos_q - ONE;
            TOS_LD_ARG: tos_nx = arg_q;
            TOS_LD_N:   tos_nx = n_opd;
            default:    tos_nx = tos_q;
        endcase
    end

    always_comb begin
        arg_nx = arg_q;
        case (arg_act_e'(arg_act))
            ARG_DEC:  arg_nx = arg_q - ONE;
            ARG_INC4: arg_nx = arg_q + STEP;
            ARG_CLR:  arg_nx = '0;
            ARG_LD_N: arg_nx = n_opd;
            default:  arg_nx = arg_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tos_q <= '0;
            arg_q <= '0;
        end else begin
            tos_q <= tos_nx;
            arg_q <= arg_nx;
        end
    end

    p_tos_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tos_act == 3'd1) |=> (tos_q == $past(tos_q) + ONE));
    p_tos_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tos_act == 3'd2) |=> (tos_q == $past(tos_q) - ONE));
    p_arg_inc4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_act == 3'd2) |=> (arg_q == $past(arg_q) + STEP));
    p_arg_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_act == 3'd3) |=> (arg_q == '0));

endmodule

// File: rtl/raddr_sel_mux.sv
module raddr_sel_mux
    import raddr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [1:0]    rd1_sel,
    input  logic [3:0]    rd2_sel,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] tos_q,
    input  logic [AW-1:0] arg_q,
    input  logic [AW-1:0] tos_nx,
    input  logic [AW-1:0] k_lo,
    input  logic [AW-1:0] n_opd,
    output logic [AW-1:0] rd1_log,
    output logic [AW-1:0] rd2_log,
    output logic [AW-1:0] wr_log,
    output logic [2:0]    d2_src,
    output logic [2:0]    d2_const
);
    always_comb begin
        case (ptr_sel_e'(rd1_sel))
            SEL_TOS: rd1_log = tos_q;
            SEL_K:   rd1_log = k_lo;
            SEL_N:   rd1_log = n_opd;
            default: rd1_log = arg_q;
        endcase
    end

    always_comb begin
        case (ptr_sel_e'(wr_sel))
            SEL_TOS: wr_log = tos_nx;
            SEL_K:   wr_log = k_lo;
            SEL_N:   wr_log = n_opd;
            default: wr_log = arg_q;
        endcase
    end

    always_comb begin
        rd2_log  = '0;
        d2_const = '0;
        d2_src   = D2_NONE;
        if (rd2_sel[3]) begin
            d2_src   = D2_CONST;
            d2_const = rd2_sel[2:0];
        end else begin
            case (rd2_sel[2:0])
                3'd0: begin d2_src = D2_REG; rd2_log = rd1_log - AW'(1); end
                3'd1: d2_src = D2_IBUF;
                3'd2: d2_src = D2_PCQ;
                3'd3: begin d2_src = D2_REG; rd2_log = tos_q; end
                3'd4: d2_src = D2_OPC;
                default: d2_src = D2_NONE;
            endcase
        end
    end

endmodule

// File: rtl/raddr_bank_tag.sv
module raddr_bank_tag #(
    parameter int AW        = 6,
    parameter int TEMP_BASE = 48,
    parameter int TEMP_CNT  = 8
) (
    input  logic [AW-1:0] log_addr,
    input  logic          frame_sel,
    output logic [AW:0]   phys_addr
);
    localparam logic [AW:0] LO = (AW+1)'(TEMP_BASE);
    localparam logic [AW:0] HI = (AW+1)'(TEMP_BASE + TEMP_CNT);

    logic is_temp;

    always_comb begin
        is_temp   = ({1'b0, log_addr} >= LO) && ({1'b0, log_addr} < HI);
        phys_addr = {(frame_sel & ~is_temp), log_addr};
    end

endmodule

// File: rtl/stack_raddr_unit.sv
module stack_raddr_unit
    import raddr_pkg::*;
#(
    parameter int AW        = 6,
    parameter int KW        = 8,
    parameter int ARG_STEP  = 4,
    parameter int TEMP_BASE = 48,
    parameter int TEMP_CNT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    rd1_sel,
    input  logic [3:0]    rd2_sel,
    input  logic          swap_in,
    input  logic [1:0]    wr_sel,
    input  logic [2:0]    tos_act,
    input  logic [2:0]    arg_act,
    input  logic          wr_req,
    input  logic          cond_wr,
    input  logic          cond_true,
    input  logic          frame_sel,
    input  logic [KW-1:0] k_const,
    input  logic [AW-1:0] n_opd,
    output logic [AW:0]   rd1_addr,
    output logic [AW:0]   rd2_addr,
    output logic [2:0]    d2_src,
    output logic [2:0]    d2_const,
    output logic          opnd_swap,
    output logic [AW:0]   wr_addr,
    output logic          wr_en,
    output logic          arg_zero,
    output logic          arg_gt_tos
);
    localparam int NPORT = 3;

    logic [AW-1:0] tos_q, arg_q, tos_nx;
    logic [AW-1:0] log_addr [NPORT];
    logic [AW:0]   phys     [NPORT];
    logic [2:0]    d2_src_w;

    raddr_ptr_unit #(.AW(AW), .ARG_STEP(ARG_STEP)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tos_act (tos_act),
        .arg_act (arg_act),
        .n_opd   (n_opd),
        .tos_q   (tos_q),
        .arg_q   (arg_q),
        .tos_nx  (tos_nx)
    );

    raddr_sel_mux #(.AW(AW)) u_mux (
        .rd1_sel  (rd1_sel),
        .rd2_sel  (rd2_sel),
        .wr_sel   (wr_sel),
        .tos_q    (tos_q),
        .arg_q    (arg_q),
        .tos_nx   (tos_nx),
        .k_lo     (k_const[AW-1:0]),
        .n_opd    (n_opd),
        .rd1_log  (log_addr[0]),
        .rd2_log  (log_addr[1]),
        .wr_log   (log_addr[2]),
        .d2_src   (d2_src_w),
        .d2_const (d2_const)
    );

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_tag
        raddr_bank_tag #(.AW(AW), .TEMP_BASE(TEMP_BASE), .TEMP_CNT(TEMP_CNT)) u_tag (
            .log_addr  (log_addr[gi]),
            .frame_sel (frame_sel),
            .phys_addr (phys[gi])
        );
    end

    always_comb begin
        rd1_addr   = phys[0];
        rd2_addr   = (d2_src_w == D2_REG) ? phys[1] : '0;
        wr_addr    = phys[2];
        d2_src     = d2_src_w;
        opnd_swap  = swap_in;
        wr_en      = wr_req & (~cond_wr | cond_true);
        arg_zero   = (arg_q == '0);
        arg_gt_tos = (arg_q > tos_q);
    end

    p_wr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_wr && !cond_true) |-> !wr_en);
    p_wr_newtos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == 2'd0) |=> (tos_q == $past(wr_addr[AW-1:0])));
    p_temp_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr[AW-1:0] >= AW'(TEMP_BASE) && wr_addr[AW-1:0] < AW'(TEMP_BASE + TEMP_CNT))
        |-> !wr_addr[AW]);
    p_rd2_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (d2_src != 3'd0) |-> (rd2_addr == '0));

endmodule

// File: tb/tb_stack_raddr_unit.sv
module tb_stack_raddr_unit;

    typedef struct packed {
        logic [1:0] r1;
        logic [1:0] w;
        logic [2:0] ta;
        logic [2:0] aa;
        logic [7:0] k;
        logic [5:0] n;
        logic [5:0] e_r1;
        logic [5:0] e_r2;
        logic [5:0] e_w;
        logic       e_az;
        logic       e_gt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 2'd0, 3'd1, 3'd0, 8'd0,  6'd0,  6'd0,  6'd63, 6'd1, 1'b1, 1'b0},
        '{2'd0, 2'd0, 3'd1, 3'd2, 8'd0,  6'd0,  6'd1,  6'd0,  6'd2, 1'b1, 1'b0},
        '{2'd3, 2'd3, 3'd4, 3'd0, 8'd0,  6'd10, 6'd4,  6'd3,  6'd4, 1'b0, 1'b1},
        '{2'd1, 2'd2, 3'd2, 3'd1, 8'd37, 6'd7,  6'd37, 6'd36, 6'd7, 1'b0, 1'b0},
        '{2'd2, 2'd0, 3'd3, 3'd4, 8'd0,  6'd20, 6'd20, 6'd19, 6'd3, 1'b0, 1'b0},
        '{2'd0, 2'd0, 3'd0, 3'd3, 8'd0,  6'd0,  6'd3,  6'd2,  6'd3, 1'b0, 1'b1},
        '{2'd3, 2'd3, 3'd5, 3'd0, 8'd0,  6'd0,  6'd0,  6'd63, 6'd0, 1'b1, 1'b0},
        '{2'd0, 2'd0, 3'd2, 3'd0, 8'd0,  6'd0,  6'd3,  6'd2,  6'd2, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rd1_sel = '0;
    logic [3:0] rd2_sel = '0;
    logic       swap_in = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [2:0] tos_act = '0;
    logic [2:0] arg_act = '0;
    logic       wr_req = 1'b0;
    logic       cond_wr = 1'b0;
    logic       cond_true = 1'b0;
    logic       frame_sel = 1'b0;
    logic [7:0] k_const = '0;
    logic [5:0] n_opd = '0;
    logic [6:0] rd1_addr, rd2_addr, wr_addr;
    logic [2:0] d2_src, d2_const;
    logic       opnd_swap, wr_en, arg_zero, arg_gt_tos;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stack_raddr_unit dut (
        .clk(clk), .rst_n(rst_n), .rd1_sel(rd1_sel), .rd2_sel(rd2_sel),
        .swap_in(swap_in), .wr_sel(wr_sel), .tos_act(tos_act), .arg_act(arg_act),
        .wr_req(wr_req), .cond_wr(cond_wr), .cond_true(cond_true),
        .frame_sel(frame_sel), .k_const(k_const), .n_opd(n_opd),
        .rd1_addr(rd1_addr), .rd2_addr(rd2_addr), .d2_src(d2_src),
        .d2_const(d2_const), .opnd_swap(opnd_swap), .wr_addr(wr_addr),
        .wr_en(wr_en), .arg_zero(arg_zero), .arg_gt_tos(arg_gt_tos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] r1, input logic [3:0] r2, input logic [1:0] w,
                         input logic [2:0] ta, input logic [2:0] aa,
                         input logic [7:0] k, input logic [5:0] n);
        @(negedge clk);
        rd1_sel = r1; rd2_sel = r2; wr_sel = w; tos_act = ta; arg_act = aa;
        k_const = k; n_opd = n;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd1_sel = '0; rd2_sel = '0; wr_sel = '0; tos_act = '0; arg_act = '0;
        k_const = '0; n_opd = '0; frame_sel = 1'b0; wr_req = 1'b0;
        cond_wr = 1'b0; cond_true = 1'b0; swap_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        drive(2'd0, 4'd0, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R1 rd1_addr", 32'(rd1_addr), 32'd0);
        chk("R1 arg_zero", 32'(arg_zero), 32'd1);
        chk("R1 arg_gt_tos", 32'(arg_gt_tos), 32'd0);

        // Table walk: R2, R3, R4, R5, R6, R7
        wr_req = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].r1, 4'd0, VEC[i].w, VEC[i].ta, VEC[i].aa, VEC[i].k, VEC[i].n);
            chk("R2 rd1_addr", 32'(rd1_addr), 32'({1'b0, VEC[i].e_r1}));
            chk("R3 rd2_addr minus one", 32'(rd2_addr), 32'({1'b0, VEC[i].e_r2}));
            chk("R4 wr_addr", 32'(wr_addr), 32'({1'b0, VEC[i].e_w}));
            chk("R7 arg_zero", 32'(arg_zero), 32'(VEC[i].e_az));
            chk("R7 arg_gt_tos", 32'(arg_gt_tos), 32'(VEC[i].e_gt));
            chk("R8 wr_en unconditional", 32'(wr_en), 32'd1);
        end

        // R3 second-port sources (TOS now 2 after table)
        drive(2'd0, 4'd3, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 src tos", 32'(d2_src), 32'd0);
        chk("R3 addr tos", 32'(rd2_addr), 32'd2);
        drive(2'd0, 4'd1, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 src ibuf", 32'(d2_src), 32'd1);
        chk("R3 addr zero", 32'(rd2_addr), 32'd0);
        drive(2'd0, 4'd2, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 src pcq", 32'(d2_src), 32'd2);
        drive(2'd0, 4'd4, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 src opcode", 32'(d2_src), 32'd3);
        drive(2'd0, 4'd8, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 src const", 32'(d2_src), 32'd4);
        chk("R3 const 0", 32'(d2_const), 32'd0);
        drive(2'd0, 4'd15, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 const 7", 32'(d2_const), 32'd7);
        drive(2'd0, 4'd6, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R3 src none", 32'(d2_src), 32'd7);
        chk("R3 none addr", 32'(rd2_addr), 32'd0);

        // R8 conditional write
        cond_wr = 1'b1; cond_true = 1'b0; #0.5;
        chk("R8 blocked", 32'(wr_en), 32'd0);
        cond_true = 1'b1; #0.5;
        chk("R8 allowed", 32'(wr_en), 32'd1);
        wr_req = 1'b0; #0.5;
        chk("R8 no request", 32'(wr_en), 32'd0);
        cond_wr = 1'b0; cond_true = 1'b0;

        // R11 swap passthrough
        swap_in = 1'b1; #0.5;
        chk("R11 swap high", 32'(opnd_swap), 32'd1);
        swap_in = 1'b0; #0.5;
        chk("R11 swap low", 32'(opnd_swap), 32'd0);

        // R9 bank tagging
        frame_sel = 1'b1;
        drive(2'd1, 4'd0, 2'd1, 3'd0, 3'd0, 8'h30, 6'd0);
        chk("R9 temp 060 rd1", 32'(rd1_addr), 32'h30);
        chk("R9 temp 060 wr", 32'(wr_addr), 32'h30);
        chk("R9 frame 057 rd2", 32'(rd2_addr), 32'h6F);
        drive(2'd1, 4'd0, 2'd2, 3'd0, 3'd0, 8'h38, 6'd5);
        chk("R9 frame 070 rd1", 32'(rd1_addr), 32'h78);
        chk("R9 temp 067 rd2", 32'(rd2_addr), 32'h37);
        chk("R9 frame wr N", 32'(wr_addr), 32'h45);
        frame_sel = 1'b0;

        // R10 wrap, R5/R6 unused codes hold
        do_reset();
        drive(2'd0, 4'd0, 2'd0, 3'd2, 3'd4, 8'd0, 6'd62);
        chk("R10 wr new tos wraps", 32'(wr_addr), 32'd63);
        drive(2'd0, 4'd0, 2'd0, 3'd6, 3'd2, 8'd0, 6'd0);
        chk("R10 tos wrapped", 32'(rd1_addr), 32'd63);
        drive(2'd3, 4'd0, 2'd0, 3'd7, 3'd5, 8'd0, 6'd0);
        chk("R10 arg wrapped", 32'(rd1_addr), 32'd2);
        drive(2'd3, 4'd0, 2'd0, 3'd0, 3'd7, 8'd0, 6'd0);
        chk("R6 unused code holds", 32'(rd1_addr), 32'd2);
        drive(2'd0, 4'd0, 2'd0, 3'd0, 3'd0, 8'd0, 6'd0);
        chk("R5 unused codes hold", 32'(rd1_addr), 32'd63);
        chk("R7 gt after wrap", 32'(arg_gt_tos), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule